// File: doc/BRIEF.md
# Recency-Ordered Set-Associative Tag Store

This block is the tag half of a set-associative cache. Each lookup names a set and a tag. The block reports whether the tag was present, and in the same operation it updates that set's replacement order. It holds no data and no valid bits. Every tag entry powers up as zero, so the first tag that misses in a set simply takes the place of a zero entry.

Each set is kept as a physically ordered list. The head slot holds the most recently used tag and the tail slot holds the least recently used one. On a hit the matching tag moves to the head, and every younger entry slides one slot toward the tail. On a miss the whole list slides toward the tail, the tail entry is dropped and the new tag is placed at the head. Reads and writes are not told apart, so every miss allocates. With a single way the store acts as a direct-mapped array. The set count is a power of two, namely the line count divided by the associativity.

A controller with two states runs the request port. In `ST_IDLE` the port is ready. The transition ACCEPT (valid while ready) writes the set, registers the miss flag and moves to `ST_RESP`. In `ST_RESP` the response is valid and the port is not ready. The transition RETIRE goes back to `ST_IDLE` after one cycle with no condition. Because of this, any later request reads the updated order.

Top module: `mru_tag_store`

## Requirements
- R1: After reset every tag entry is zero, `req_ready` is 1, `rsp_valid` is 0 and `rsp_miss` is 0. A lookup of tag 0 in any set that has not been touched since reset reports a hit.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. In the following cycle `rsp_valid` is 1 for exactly one cycle and `rsp_miss` gives the result (1 = miss, 0 = hit). `rsp_miss` changes only after an acceptance.
- R3: While `rsp_valid` is 1, `req_ready` is 0. A request presented during that cycle is ignored: it gives no response and does not change any set.
- R4: A tag that matches the head slot (slot 0) is a hit and leaves the set's order unchanged.
- R5: A tag that matches slot i > 0 is a hit. Slots 0..i-1 each move one slot toward the tail, and the tag is written to slot 0. Slots after i keep their contents.
- R6: A tag that matches no slot is a miss. Every entry moves one slot toward the tail, the tail entry (slot WAYS-1) is discarded and the tag is written to slot 0.
- R7: A lookup changes only the set it addresses.
- R8: With WAYS = 1, a matching tag is a hit and a mismatch is a miss that replaces the single entry.
- R9: A lookup that immediately follows an accepted lookup of the same set and tag reports a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Store can take a request this cycle |
| req_set | input | SET_W | Set index of the lookup |
| req_tag | input | TAG_W | Tag to look up |
| rsp_valid | output | 1 | Lookup result valid this cycle |
| rsp_miss | output | 1 | 1 = miss, 0 = hit |

## Verification
The assertions check the handshake on every cycle. Each acceptance gets exactly one response in the next cycle, with ready low during that cycle. The miss flag stays stable between acceptances, and a repeated lookup of the same set and tag always hits. The replacement order itself is visible only through chosen sequences of lookups. The bench scenarios fill a set, promote entries from the middle and tail slots, evict the oldest tag, and interleave other sets. Further scenarios cover a request held during the busy cycle and a one-way instance.

// File: rtl/mru_pkg.sv
package mru_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/mru_ctrl.sv
module mru_ctrl
    import mru_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic rsp_valid,
    output logic accept
);

    ctrl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;   // ACCEPT
            ST_RESP: state_d = ST_IDLE;                  // RETIRE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
        accept = req_ready && req_valid;
    end

endmodule

// File: rtl/mru_match.sv
module mru_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 12,
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] row,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [IDX_W-1:0]           hit_idx
);

    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = (row[w] == tag);
    end

    always_comb begin
        hit     = |eq;
        hit_idx = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) hit_idx = IDX_W'(w);
        end
    end

endmodule

// File: rtl/mru_reorder.sv
module mru_reorder #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 12,
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] row,
    input  logic [TAG_W-1:0]           tag,
    input  logic                       hit,
    input  logic [IDX_W-1:0]           hit_idx,
    output logic [WAYS-1:0][TAG_W-1:0] row_next
);

    assign row_next[0] = tag;

    for (genvar j = 1; j < WAYS; j++) begin : g_slot
        logic shift_in;
        assign shift_in    = !hit || (IDX_W'(j) <= hit_idx);
        assign row_next[j] = shift_in ? row[j-1] : row[j];
    end

endmodule

// File: rtl/mru_tag_store.sv
module mru_tag_store #(
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int TAG_W = 12,
    localparam int SET_W = $clog2(SETS),
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [SET_W-1:0] req_set,
    input  logic [TAG_W-1:0] req_tag,
    output logic             rsp_valid,
    output logic             rsp_miss
);

    logic [WAYS-1:0][TAG_W-1:0] tags_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0] cur_row, new_row;
    logic                       accept, hit;
    logic [IDX_W-1:0]           hit_idx;

    mru_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .accept    (accept)
    );

    assign cur_row = tags_q[req_set];

    mru_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .row     (cur_row),
        .tag     (req_tag),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    mru_reorder #(.WAYS(WAYS), .TAG_W(TAG_W)) u_reorder (
        .row      (cur_row),
        .tag      (req_tag),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .row_next (new_row)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tags_q[s] <= '0;
            rsp_miss <= 1'b0;
        end else if (accept) begin
            tags_q[req_set] <= new_row;
            rsp_miss        <= !hit;
        end
    end

endmodule

// File: rtl/mru_tag_store_chk.sv
module mru_tag_store_chk #(
    parameter int SET_W = 3,
    parameter int TAG_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [SET_W-1:0] req_set,
    input logic [TAG_W-1:0] req_tag,
    input logic             rsp_valid,
    input logic             rsp_miss
);

    logic             acc;
    logic             last_vld;
    logic [SET_W-1:0] last_set;
    logic [TAG_W-1:0] last_tag;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_vld <= 1'b0;
            last_set <= '0;
            last_tag <= '0;
        end else if (acc) begin
            last_vld <= 1'b1;
            last_set <= req_set;
            last_tag <= req_tag;
        end
    end

    // R2
    resp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    // R2
    miss_flag_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(rsp_miss));

    // R3
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R3
    ready_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R9
    repeat_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && last_vld && req_set == last_set && req_tag == last_tag) |=> !rsp_miss);

endmodule

bind mru_tag_store mru_tag_store_chk #(.SET_W(SET_W), .TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_set   (req_set),
    .req_tag   (req_tag),
    .rsp_valid (rsp_valid),
    .rsp_miss  (rsp_miss)
);

// File: tb/mru_tag_store_test.sv
`timescale 1ns/1ps
module mru_tag_store_test;

    localparam int SET_W = 3;
    localparam int TAG_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             dm_valid = 1'b0;
    logic [SET_W-1:0] req_set = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic             req_ready, rsp_valid, rsp_miss;
    logic             dm_ready, dm_rsp_valid, dm_miss;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mru_tag_store #(.SETS(8), .WAYS(4), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_set(req_set), .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss));

    mru_tag_store #(.SETS(4), .WAYS(1), .TAG_W(TAG_W)) uut_dm (
        .clk(clk), .rst_n(rst_n), .req_valid(dm_valid), .req_ready(dm_ready),
        .req_set(req_set[1:0]), .req_tag(req_tag), .rsp_valid(dm_rsp_valid), .rsp_miss(dm_miss));

    localparam logic [TAG_W-1:0] TA = 12'h0A1, TB = 12'h0B2, TC = 12'h0C3,
                                 TD = 12'h0D4, TE = 12'h0E5, TZ = 12'h5A5;

    // {set, tag, expected miss}
    localparam int NV = 17;
    localparam logic [SET_W+TAG_W:0] VEC [NV] = '{
        {3'd2, 12'h000, 1'b0},  // R1 zero tag hits after reset
        {3'd2, TA, 1'b1},       // R6
        {3'd2, TB, 1'b1},
        {3'd2, TC, 1'b1},
        {3'd2, TD, 1'b1},       // [D C B A]
        {3'd2, TD, 1'b0},       // R4 head hit
        {3'd2, TB, 1'b0},       // R5 -> [B D C A]
        {3'd2, TE, 1'b1},       // R6 evicts A -> [E B D C]
        {3'd2, TA, 1'b1},       // R6 evicts C -> [A E B D]
        {3'd2, TC, 1'b1},       // -> [C A E B]
        {3'd2, TB, 1'b0},       // R5 tail hit -> [B C A E]
        {3'd5, TA, 1'b1},       // R7 other set
        {3'd5, 12'h000, 1'b0},  // R7
        {3'd2, TE, 1'b0},       // R5 -> [E B C A]
        {3'd2, TD, 1'b1},       // -> [D E B C]
        {3'd2, TA, 1'b1},       // R6 A evicted previously
        {3'd7, 12'h000, 1'b0}   // R1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [SET_W-1:0] s, input logic [TAG_W-1:0] t,
                          input string req, input logic exp_miss);
        while (!req_ready) @(negedge clk);
        req_set = s; req_tag = t; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);   // R2
        chk({req, " ready low"}, 32'(req_ready), 32'd0);   // R3
        chk({req, " miss"}, 32'(rsp_miss), 32'(exp_miss));
        @(negedge clk);
        chk("R2 single-cycle rsp_valid", 32'(rsp_valid), 32'd0);
    endtask

    task automatic dm_lookup(input logic [TAG_W-1:0] t, input logic exp_miss);
        req_set = 3'd1; req_tag = t; dm_valid = 1'b1;
        @(negedge clk);
        dm_valid = 1'b0;
        chk("R8 dm rsp_valid", 32'(dm_rsp_valid), 32'd1);
        chk("R8 dm miss", 32'(dm_miss), 32'(exp_miss));
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 rsp_miss after reset", 32'(rsp_miss), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            lookup(VEC[i][SET_W+TAG_W:TAG_W+1], VEC[i][TAG_W:1],
                   $sformatf("R4/R5/R6 vec%0d", i), VEC[i][0]);
        end

        // R9 back-to-back same set and tag
        lookup(3'd3, TC, "R9 first", 1'b1);
        lookup(3'd3, TC, "R9 repeat", 1'b0);

        // R3 request during busy cycle is ignored
        while (!req_ready) @(negedge clk);
        req_set = 3'd4; req_tag = TA; req_valid = 1'b1;
        @(negedge clk);                    // accepted, now busy
        req_tag = TZ; req_set = 3'd6;      // held during busy cycle
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 no response to busy-cycle request", 32'(rsp_valid), 32'd0);
        lookup(3'd6, TZ, "R3 ignored tag absent", 1'b1);
        lookup(3'd6, 12'h000, "R3 zero still present", 1'b0);

        // R8 direct-mapped instance
        dm_lookup(12'h000, 1'b0);
        dm_lookup(TA, 1'b1);
        dm_lookup(TA, 1'b0);
        dm_lookup(TB, 1'b1);
        dm_lookup(TA, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule